// File: doc/BRIEF.md
# Multi-channel PWM generator with linear duty fade

This block drives several PWM outputs from one shared period counter. Each channel has its own duty level and its own phase offset. A channel turns its output on at a programmable tick within the period, called the high point, and keeps it on for `duty` ticks. A hardware engine on each channel can ramp the duty level linearly toward a target, one level at a time. When the ramp lands on the target, the channel raises a one-cycle completion pulse.

Host software writes every setting through one write port. A write carries a register select, a channel number and a 32-bit data word.

The global timer setting has two fields:
- the counter resolution, which sets the period length;
- a prescale divider on the counter tick.

Each channel has four settings:
- duty;
- high point;
- fade request (target level and ramp rate);
- run/stop with an idle level.

Duty and high-point writes are held in shadow registers and take effect at the next counter wrap. Fades also start only at a wrap. A period is therefore never cut short or stretched by a write. Conversion from frequency or milliseconds into resolution, prescale and step counts is done by software.

Top module: `pwm_fade_top`

## Requirements
- R1: A write with select 0 sets the timer for all channels at once. `data[4:0]` is the resolution `res`: 0 is taken as 1, and values above 20 are taken as 20. `data[23:8]` is the prescale `P`. The counter advances once every `P+1` clocks and wraps after `2^res` ticks, so the largest duty level is `2^res-1`. The write restarts the counter at 0.
- R2: A write with select 1 puts `data[19:0]` into the channel's duty shadow. The shadow value becomes active at the next counter wrap. A running channel is high for exactly `duty` ticks of every period, and a duty of 0 keeps it constantly low.
- R3: A write with select 2 sets the high point `hp` (`data[19:0]`), which also takes effect at the next wrap. The output is high while `(count - hp) mod 2^res < duty`, so the on-window can wrap past the end of the period.
- R4: A write with select 3 requests a fade, with target `data[19:0]` and step interval `data[29:20]` in periods. The fade is accepted at the next wrap. After that, the duty moves one level toward the target at every `interval`-th wrap. The done pulse comes on the wrap at which the duty reaches the target.
- R5: A step interval of 0 is treated as 1.
- R6: If the target equals the duty at the wrap that accepts the fade, done is raised at that wrap and no step is made.
- R7: `busy_o` for a channel goes high in the cycle after a fade write. It stays high until the cycle in which done is raised, and is low in that cycle.
- R8: `done_o` for a channel is high for exactly one clock cycle per completed fade.
- R9: A write with select 4 sets run (`data[0]`) and the idle level (`data[1]`). A stopped channel drives its idle level. After reset every channel is stopped with idle level 0, and all outputs are low.
- R10: A duty write cancels any pending or active fade on that channel. Busy drops in the next cycle and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select (0 timer, 1 duty, 2 high point, 3 fade, 4 run) |
| wr_ch_i | input | CHW | Target channel (ignored for the timer) |
| wr_data_i | input | 32 | Write data |
| pwm_o | output | NCH | PWM outputs, one per channel |
| busy_o | output | NCH | Fade pending or in progress, per channel |
| done_o | output | NCH | One-cycle fade completion pulse, per channel |

## Verification
The assertions check the following properties on every cycle:
- a wrap always brings the counter back to 0;
- the active duty changes only at a wrap;
- a stopped channel shows its idle level;
- a running channel with zero duty stays low;
- done is a single-cycle pulse that follows busy and never overlaps it.

Only the bench scenarios can show the properties that depend on time or on the shape of the waveform:
- the on-time counted over a period;
- the phase offset between two channels;
- the effect of prescale and of resolution clamping;
- the total length of a fade for a given step interval, including an interval of 0 and a target equal to the current duty;
- that a duty write cancels a fade.

// File: rtl/pwm_fade_pkg.sv
package pwm_fade_pkg;
  localparam int DATA_W = 32;
  localparam int RES_W  = 5;
  localparam int PRE_LSB = 8;

  typedef enum logic [2:0] {
    SEL_TIMER  = 3'd0,
    SEL_DUTY   = 3'd1,
    SEL_HPOINT = 3'd2,
    SEL_FADE   = 3'd3,
    SEL_RUN    = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_fade_pkg::*;
#(
  parameter int CW = 20,
  parameter int PW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [RES_W-1:0] res_i,
  input  logic [PW-1:0]    pre_i,
  output logic [CW-1:0]    cnt_o,
  output logic [CW-1:0]    mask_o,
  output logic             wrap_o
);
  logic [RES_W-1:0] res_q;
  logic [PW-1:0]    pre_q, pc_q;
  logic [CW-1:0]    cnt_q;
  logic             tick;

  function automatic logic [RES_W-1:0] clamp_res(input logic [RES_W-1:0] r);
    if (r == '0) return RES_W'(1);
    if (int'(r) > CW) return RES_W'(CW);
    return r;
  endfunction

  assign mask_o = {CW{1'b1}} >> (CW - int'(res_q));
  assign tick   = (pc_q >= pre_q);
  assign wrap_o = tick && (cnt_q >= mask_o);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= RES_W'(1);
      pre_q <= '0;
      pc_q  <= '0;
      cnt_q <= '0;
    end else if (cfg_we_i) begin
      res_q <= clamp_res(res_i);
      pre_q <= pre_i;
      pc_q  <= '0;
      cnt_q <= '0;
    end else begin
      pc_q <= tick ? '0 : pc_q + PW'(1);
      if (tick) cnt_q <= wrap_o ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_fade_pkg::*;
#(
  parameter int CW  = 20,
  parameter int CNW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     cnt_i,
  input  logic [CW-1:0]     mask_i,
  input  logic              wrap_i,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pwm_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CW-1:0]     duty_o,
  output logic              run_o,
  output logic              idle_o
);
  logic [CW-1:0]  duty_q, duty_sh, hp_q, hp_sh, tgt_q, tgt_sh;
  logic           duty_pend, hp_pend;
  logic [CNW-1:0] cyc_q, cyc_sh, step_cnt;
  logic           f_pend, f_act, done_q, run_q, idle_q;
  logic [CW-1:0]  d_cur, d_next, phase;
  logic [CNW-1:0] cyc_in;
  logic           unused_data;

  assign unused_data = ^data_i;
  assign cyc_in = data_i[CW +: CNW];
  assign d_cur  = duty_pend ? duty_sh : duty_q;
  assign d_next = (tgt_q > duty_q) ? duty_q + CW'(1) : duty_q - CW'(1);
  assign phase  = (cnt_i - hp_q) & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0; duty_sh <= '0; duty_pend <= 1'b0;
      hp_q <= '0; hp_sh <= '0; hp_pend <= 1'b0;
      tgt_q <= '0; tgt_sh <= '0; cyc_q <= '0; cyc_sh <= '0;
      step_cnt <= '0; f_pend <= 1'b0; f_act <= 1'b0; done_q <= 1'b0;
      run_q <= 1'b0; idle_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      // period boundary: shadows load, fade accept or step
      if (wrap_i) begin
        if (duty_pend) begin
          duty_q    <= duty_sh;
          duty_pend <= 1'b0;
        end
        if (hp_pend) begin
          hp_q    <= hp_sh;
          hp_pend <= 1'b0;
        end
        if (f_pend) begin
          f_pend   <= 1'b0;
          tgt_q    <= tgt_sh;
          cyc_q    <= cyc_sh;
          step_cnt <= '0;
          if (d_cur == tgt_sh) begin
            done_q <= 1'b1;
            f_act  <= 1'b0;
          end else begin
            f_act <= 1'b1;
          end
        end else if (f_act) begin
          if (step_cnt == cyc_q - CNW'(1)) begin
            step_cnt <= '0;
            duty_q   <= d_next;
            if (d_next == tgt_q) begin
              done_q <= 1'b1;
              f_act  <= 1'b0;
            end
          end else begin
            step_cnt <= step_cnt + CNW'(1);
          end
        end
      end
      // register writes override boundary updates
      if (we_i) begin
        unique case (sel_i)
          SEL_DUTY: begin
            duty_sh   <= data_i[CW-1:0];
            duty_pend <= 1'b1;
            f_pend    <= 1'b0;
            f_act     <= 1'b0;
            done_q    <= 1'b0;
          end
          SEL_HPOINT: begin
            hp_sh   <= data_i[CW-1:0];
            hp_pend <= 1'b1;
          end
          SEL_FADE: begin
            tgt_sh <= data_i[CW-1:0];
            cyc_sh <= (cyc_in == '0) ? CNW'(1) : cyc_in;
            f_pend <= 1'b1;
          end
          SEL_RUN: begin
            run_q  <= data_i[0];
            idle_q <= data_i[1];
          end
          default: ;
        endcase
      end
    end
  end

  assign pwm_o  = run_q ? (phase < duty_q) : idle_q;
  assign busy_o = f_pend | f_act;
  assign done_o = done_q;
  assign duty_o = duty_q;
  assign run_o  = run_q;
  assign idle_o = idle_q;
endmodule

// File: rtl/pwm_fade_top.sv
module pwm_fade_top
  import pwm_fade_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 20,
  parameter int PW  = 16,
  parameter int CNW = 10,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [CHW-1:0]    wr_ch_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NCH-1:0]    pwm_o,
  output logic [NCH-1:0]    busy_o,
  output logic [NCH-1:0]    done_o
);
  reg_sel_e          sel;
  logic              timer_we;
  logic [CW-1:0]     cnt_w, mask_w;
  logic              wrap_w;
  logic [NCH*CW-1:0] duty_w;
  logic [NCH-1:0]    run_w, idle_w;

  assign sel      = reg_sel_e'(wr_sel_i);
  assign timer_we = wr_en_i && (sel == SEL_TIMER);

  pwm_timebase #(.CW(CW), .PW(PW)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_we_i (timer_we),
    .res_i    (wr_data_i[RES_W-1:0]),
    .pre_i    (wr_data_i[PRE_LSB +: PW]),
    .cnt_o    (cnt_w),
    .mask_o   (mask_w),
    .wrap_o   (wrap_w)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic ch_we;
    assign ch_we = wr_en_i && (int'(wr_ch_i) == i) && (sel != SEL_TIMER);

    pwm_chan #(.CW(CW), .CNW(CNW)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt_w),
      .mask_i (mask_w),
      .wrap_i (wrap_w),
      .we_i   (ch_we),
      .sel_i  (sel),
      .data_i (wr_data_i),
      .pwm_o  (pwm_o[i]),
      .busy_o (busy_o[i]),
      .done_o (done_o[i]),
      .duty_o (duty_w[i*CW +: CW]),
      .run_o  (run_w[i]),
      .idle_o (idle_w[i])
    );
  end
endmodule

// File: rtl/pwm_fade_chk.sv
module pwm_fade_chk #(
  parameter int NCH = 4,
  parameter int CW  = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wrap_i,
  input logic [CW-1:0]     cnt_i,
  input logic [NCH-1:0]    pwm_i,
  input logic [NCH-1:0]    busy_i,
  input logic [NCH-1:0]    done_i,
  input logic [NCH-1:0]    run_i,
  input logic [NCH-1:0]    idle_i,
  input logic [NCH*CW-1:0] duty_i
);
  assert_wrap_restart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (cnt_i == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_duty_at_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap_i |=> $stable(duty_i[i*CW +: CW]));
    assert_zero_duty_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i[i] && duty_i[i*CW +: CW] == '0) |-> !pwm_i[i]);
    assert_done_not_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[i] |-> !busy_i[i]);
    assert_done_after_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[i] |-> $past(busy_i[i]));
    assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[i] |=> !done_i[i]);
    assert_idle_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i[i] |-> (pwm_i[i] == idle_i[i]));
  end
endmodule

bind pwm_fade_top pwm_fade_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wrap_i (wrap_w),
  .cnt_i  (cnt_w),
  .pwm_i  (pwm_o),
  .busy_i (busy_o),
  .done_i (done_o),
  .run_i  (run_w),
  .idle_i (idle_w),
  .duty_i (duty_w)
);

// File: tb/sim_pwm_fade_top.sv
`timescale 1ns/1ps
module sim_pwm_fade_top;
  localparam int NCH = 2;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [0:0]  wr_ch_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [NCH-1:0] pwm_o, busy_o, done_o;
  int total = 0, bad = 0, cyc = 0;

  pwm_fade_top #(.NCH(NCH)) u0 (.*);

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int ch, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = 3'(sel); wr_ch_i = 1'(ch); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic highs(input int ch, input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      if (pwm_o[ch]) c++;
    end
  endtask

  task automatic wait_done(input int ch, output int n);
    n = 0;
    while (!done_o[ch] && n < 400) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic t_reset;
    check(pwm_o == '0, "R9 reset pwm", int'(pwm_o), 0);
    check(busy_o == '0 && done_o == '0, "R9 reset busy/done", int'({busy_o, done_o}), 0);
  endtask

  task automatic t_duty;
    int c;
    wr(0, 0, 32'd3);            // res 3, prescale 0
    wr(4, 0, 32'd1); wr(4, 1, 32'd1);
    wr(1, 0, 32'd3); wr(1, 1, 32'd5);
    idle(20);
    highs(0, 8, c); check(c == 3, "R2 duty 3 on-time", c, 3);
    highs(1, 8, c); check(c == 5, "R2 duty 5 on-time", c, 5);
    wr(1, 0, 32'd0); idle(20);
    highs(0, 16, c); check(c == 0, "R2 duty 0 low", c, 0);
  endtask

  task automatic t_timer;
    int c;
    wr(1, 0, 32'd3);
    wr(0, 0, 32'd3 | (32'd1 << 8)); idle(40);
    highs(0, 16, c); check(c == 6, "R1 prescale 1", c, 6);
    wr(0, 0, 32'd2); idle(20);
    highs(0, 8, c); check(c == 6, "R1 res 2 shared", c, 6);
    highs(1, 8, c); check(c == 8, "R1 res 2 duty>max", c, 8);
    wr(0, 0, 32'd0); wr(1, 0, 32'd1); idle(20);
    highs(0, 8, c); check(c == 4, "R1 res 0 clamps to 1", c, 4);
    wr(0, 0, 32'd3); idle(20);
  endtask

  task automatic t_phase;
    logic s0[24], s1[24];
    int mis = 0, c;
    wr(1, 0, 32'd3); wr(1, 1, 32'd3);
    wr(2, 0, 32'd0); wr(2, 1, 32'd2);
    idle(20);
    for (int k = 0; k < 24; k++) begin
      @(negedge clk_i); s0[k] = pwm_o[0]; s1[k] = pwm_o[1];
    end
    for (int k = 2; k < 24; k++) if (s1[k] != s0[k-2]) mis++;
    check(mis == 0, "R3 hp 2 delays window", mis, 0);
    wr(2, 1, 32'd6); wr(1, 1, 32'd4); idle(20);
    highs(1, 8, c); check(c == 4, "R3 window wraps period", c, 4);
  endtask

  task automatic t_fade;
    int n, c;
    wr(1, 0, 32'd0); idle(20);
    wr(3, 0, 32'd5 | (32'd2 << 20));
    check(busy_o[0] == 1'b1, "R7 busy after fade write", int'(busy_o[0]), 1);
    wait_done(0, n);
    check(n >= 81 && n <= 88, "R4 fade length 5 levels x 2", n, 84);
    check(busy_o[0] == 1'b0, "R7 busy low with done", int'(busy_o[0]), 0);
    @(negedge clk_i);
    check(done_o[0] == 1'b0, "R8 done one cycle", int'(done_o[0]), 0);
    highs(0, 8, c); check(c == 5, "R4 duty at target", c, 5);
  endtask

  task automatic t_cyc0;
    int n, c;
    wr(3, 0, 32'd2);
    wait_done(0, n);
    check(n >= 25 && n <= 32, "R5 interval 0 as 1", n, 28);
    idle(2);
    highs(0, 8, c); check(c == 2, "R5 duty at target", c, 2);
  endtask

  task automatic t_equal;
    int n, c;
    wr(3, 0, 32'd2 | (32'd5 << 20));
    wait_done(0, n);
    check(n >= 1 && n <= 8, "R6 equal target done at boundary", n, 4);
    idle(2);
    highs(0, 8, c); check(c == 2, "R6 duty unchanged", c, 2);
  endtask

  task automatic t_cancel;
    int c, seen = 0;
    wr(3, 0, 32'd7 | (32'd4 << 20));
    idle(20);
    wr(1, 0, 32'd1);
    check(busy_o[0] == 1'b0, "R10 busy cleared", int'(busy_o[0]), 0);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk_i); if (done_o[0]) seen++;
    end
    check(seen == 0, "R10 no done after cancel", seen, 0);
    highs(0, 8, c); check(c == 1, "R10 written duty holds", c, 1);
  endtask

  task automatic t_stop;
    int c;
    wr(4, 0, 32'd2); idle(2);
    highs(0, 16, c); check(c == 16, "R9 stopped idle 1", c, 16);
    wr(4, 0, 32'd0); idle(2);
    highs(0, 16, c); check(c == 0, "R9 stopped idle 0", c, 0);
  endtask

  initial begin
    idle(3);
    t_reset;
    rst_ni = 1'b1;
    idle(2);
    t_reset;
    t_duty;
    t_timer;
    t_phase;
    t_fade;
    t_cyc0;
    t_equal;
    t_cancel;
    t_stop;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule